// File: doc/BRIEF.md
# Data Toggle Sequence Tracker

This block holds the one-bit data sequence state of a single endpoint pipe, once for the direction in which the endpoint receives data and once for the direction in which it sends data. Each time a received data packet ends, the block takes the decoded token type, the sequence value carried by the data PID, a packet-good flag, a buffer-ready flag and a halted flag. From these it decides whether the payload is to be kept, dropped as a repeat, or refused, and which handshake goes back to the sender. The decision and the handshake code appear in the clock cycle after the packet-end strobe.

On the sending side, the block takes the outcome of each handshake phase and moves its transmit bit only when that outcome is an acknowledgement. The bit is presented continuously, so the packet builder always knows which data PID to use for the next packet or for a retry. A valid SETUP stage forces both bits to 1. A synchronous reset or a clear request forces both bits to 0.

Top module: `seq_bit_tracker`

## Requirements
- R1: After synchronous active-low reset, the receive bit `rx_seq` and the transmit bit `tx_pid_seq` are 0, both strobes are low and `rx_hs` is 00 (none). Bit value 0 means DATA0 and bit value 1 means DATA1.
- R2: A pulse on `clear_seq` sets both bits to 0 at the next clock edge. It overrides any bit update that is requested in the same cycle.
- R3: A good packet ending under token code 11 (SETUP) is always taken, whatever its PID, the buffer state or the halted state. The block pulses `rx_accept`, returns 01 (ACK), and sets both bits to 1. This also wins over a transmit acknowledgement in the same cycle.
- R4: A good packet under token code 01 (OUT) is taken when the endpoint is not halted, the buffer is ready and the PID sequence value equals `rx_seq`. The block pulses `rx_accept`, returns ACK and inverts `rx_seq`.
- R5: A good OUT packet whose PID sequence value differs from `rx_seq`, with the buffer ready and the endpoint not halted, is treated as a repeat. The block pulses `rx_discard`, still returns ACK and leaves `rx_seq` unchanged.
- R6: A good OUT packet that arrives while the buffer is not ready and the endpoint is not halted gets 10 (NAK). There are no strobes and neither bit changes.
- R7: A good OUT packet that arrives while `ep_halted` is high gets 11 (STALL). There are no strobes and no bit changes, and this takes priority over both the buffer state and the PID comparison.
- R8: A corrupted packet (`rx_pkt_ok` low) under OUT or SETUP gets no handshake (00), no strobes and no bit changes.
- R9: A packet-end strobe under token code 00 (none) or 10 (IN) counts as a transaction without a received data phase. It changes nothing and produces no output.
- R10: A transmit result with `tx_res_valid` high inverts `tx_pid_seq` only for code 00 (ACK). Codes 01 (NAK), 10 (STALL) and 11 (timeout or corrupted handshake) leave it unchanged, so a retry reuses the same PID.
- R11: `rx_accept`, `rx_discard` and `rx_hs` come from registers. They are valid for exactly one cycle, the cycle after `rx_pkt_end`, and return to zero the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_seq | input | 1 | Request to set both sequence bits to 0 |
| rx_pkt_end | input | 1 | One-cycle strobe marking the end of a received packet |
| rx_token | input | 2 | Token of the transaction: 00 none, 01 OUT, 10 IN, 11 SETUP |
| rx_pid_seq | input | 1 | Sequence value of the received data PID (0 DATA0, 1 DATA1) |
| rx_pkt_ok | input | 1 | Received packet passed its integrity checks |
| rx_can_accept | input | 1 | Receive buffer has room for the payload |
| ep_halted | input | 1 | Endpoint halted; refusals become STALL |
| tx_res_valid | input | 1 | One-cycle strobe carrying the result of a transmit handshake |
| tx_res | input | 2 | Transmit result: 00 ACK, 01 NAK, 10 STALL, 11 timeout or bad handshake |
| rx_accept | output | 1 | Payload is to be kept |
| rx_discard | output | 1 | Payload is a repeat and is to be dropped |
| rx_hs | output | 2 | Handshake to return: 00 none, 01 ACK, 10 NAK, 11 STALL |
| rx_seq | output | 1 | Current receive sequence bit |
| tx_pid_seq | output | 1 | Sequence value to put in the next transmitted data PID |

## Verification
The bench visits every combination of token, PID value, packet-good, buffer-ready and halted flags, starting from each of the four combinations of receive and transmit bits, and compares each result with a model in the bench. That model is derived from the requirements, not from the RTL.

It targets the following faults:
- Confusing a repeat with a refusal. A NAK here would make the sender resend forever, and toggling on it would lose a packet.
- Getting the halted-versus-busy priority wrong. This returns NAK where STALL belongs.
- Letting a corrupted SETUP move the bits.
- Toggling the transmit bit on a timeout. That would send a retry under the wrong PID.

It also checks the same-cycle collisions of clear with a data packet and of SETUP with a transmit acknowledgement, and it confirms that every strobe drops after one cycle.

// File: rtl/seqtrk_pkg.sv
// Shared encodings for the data toggle sequence tracker.
// Assumes two-bit codes at the top-level ports; the enums give them names.
package seqtrk_pkg;

    // Token of the transaction in progress when a packet ends.
    typedef enum logic [1:0] {
        TOK_NONE  = 2'b00,
        TOK_OUT   = 2'b01,
        TOK_IN    = 2'b10,
        TOK_SETUP = 2'b11
    } tok_e;

    // Handshake returned by the receive side.
    typedef enum logic [1:0] {
        HS_NONE  = 2'b00,
        HS_ACK   = 2'b01,
        HS_NAK   = 2'b10,
        HS_STALL = 2'b11
    } hs_e;

    // Outcome seen by the transmit side after sending a data packet.
    typedef enum logic [1:0] {
        RES_ACK     = 2'b00,
        RES_NAK     = 2'b01,
        RES_STALL   = 2'b10,
        RES_TIMEOUT = 2'b11
    } txres_e;

    // Decision taken for one received packet.
    typedef enum logic [2:0] {
        V_IGNORE = 3'd0,
        V_TAKE   = 3'd1,
        V_DUP    = 3'd2,
        V_BUSY   = 3'd3,
        V_HALT   = 3'd4,
        V_SETUP  = 3'd5
    } verdict_e;

endpackage

// File: rtl/seqtrk_rx_judge.sv
// Combinational judge for one received packet.
// Produces a verdict from the token, the packet flags and the current
// receive bit. Assumes pkt_end is a single-cycle strobe; when it is low the
// verdict is V_IGNORE.
module seqtrk_rx_judge
    import seqtrk_pkg::*;
(
    input  logic     pkt_end,
    input  tok_e     tok,
    input  logic     pid_seq,
    input  logic     pkt_ok,
    input  logic     can_accept,
    input  logic     halted,
    input  logic     cur_seq,
    output verdict_e verdict
);

    // Priority: corrupted > SETUP > halted > buffer full > PID match.
    always_comb begin
        verdict = V_IGNORE;
        if (pkt_end && pkt_ok) begin
            unique case (tok)
                TOK_SETUP: verdict = V_SETUP;
                TOK_OUT: begin
                    if (halted)                 verdict = V_HALT;
                    else if (!can_accept)       verdict = V_BUSY;
                    else if (pid_seq == cur_seq) verdict = V_TAKE;
                    else                        verdict = V_DUP;
                end
                default:   verdict = V_IGNORE;
            endcase
        end
    end

endmodule

// File: rtl/seqtrk_rx_state.sv
// Receive-side sequence bit and registered response outputs.
// Assumes verdict comes from seqtrk_rx_judge in the same cycle; the
// strobes and handshake are valid for the single following cycle.
module seqtrk_rx_state
    import seqtrk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  verdict_e verdict,
    output logic     seq,
    output logic     accept,
    output logic     discard,
    output hs_e      hs
);

    hs_e  hs_next;
    logic acc_next;
    logic dis_next;

    // Map a verdict onto the handshake and strobes.
    always_comb begin
        hs_next  = HS_NONE;
        acc_next = 1'b0;
        dis_next = 1'b0;
        unique case (verdict)
            V_SETUP, V_TAKE: begin hs_next = HS_ACK; acc_next = 1'b1; end
            V_DUP:           begin hs_next = HS_ACK; dis_next = 1'b1; end
            V_BUSY:          hs_next = HS_NAK;
            V_HALT:          hs_next = HS_STALL;
            default:         hs_next = HS_NONE;
        endcase
    end

    // Sequence bit: clear wins, SETUP forces 1, a kept packet toggles.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)         seq <= 1'b0;
        else if (verdict == V_SETUP) seq <= 1'b1;
        else if (verdict == V_TAKE)  seq <= ~seq;
    end

    // One-cycle registered response outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs      <= HS_NONE;
            accept  <= 1'b0;
            discard <= 1'b0;
        end else begin
            hs      <= hs_next;
            accept  <= acc_next;
            discard <= dis_next;
        end
    end

endmodule

// File: rtl/seqtrk_tx_state.sv
// Transmit-side sequence bit.
// Toggles only on an acknowledged send; a SETUP stage forces it to 1.
// Assumes res_valid is a single-cycle strobe.
module seqtrk_tx_state
    import seqtrk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   setup_sync,
    input  logic   res_valid,
    input  txres_e res,
    output logic   seq
);

    // Clear wins, SETUP forces 1, ACK toggles, other outcomes hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                  seq <= 1'b0;
        else if (setup_sync)                  seq <= 1'b1;
        else if (res_valid && res == RES_ACK) seq <= ~seq;
    end

endmodule

// File: rtl/seq_bit_tracker.sv
// Data toggle sequence tracker for one endpoint pipe.
// Combines the receive judge, the receive state and the transmit state.
// Assumes rx_pkt_end and tx_res_valid are single-cycle strobes from the
// packet layer.
module seq_bit_tracker
    import seqtrk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_seq,
    input  logic       rx_pkt_end,
    input  logic [1:0] rx_token,
    input  logic       rx_pid_seq,
    input  logic       rx_pkt_ok,
    input  logic       rx_can_accept,
    input  logic       ep_halted,
    input  logic       tx_res_valid,
    input  logic [1:0] tx_res,
    output logic       rx_accept,
    output logic       rx_discard,
    output logic [1:0] rx_hs,
    output logic       rx_seq,
    output logic       tx_pid_seq
);

    verdict_e verdict;
    hs_e      hs_q;
    logic     setup_hit;

    seqtrk_rx_judge i_judge (
        .pkt_end    (rx_pkt_end),
        .tok        (tok_e'(rx_token)),
        .pid_seq    (rx_pid_seq),
        .pkt_ok     (rx_pkt_ok),
        .can_accept (rx_can_accept),
        .halted     (ep_halted),
        .cur_seq    (rx_seq),
        .verdict    (verdict)
    );

    seqtrk_rx_state i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_seq),
        .verdict (verdict),
        .seq     (rx_seq),
        .accept  (rx_accept),
        .discard (rx_discard),
        .hs      (hs_q)
    );

    // A SETUP verdict resynchronizes the transmit side as well.
    assign setup_hit = (verdict == V_SETUP);

    seqtrk_tx_state i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_seq),
        .setup_sync (setup_hit),
        .res_valid  (tx_res_valid),
        .res        (txres_e'(tx_res)),
        .seq        (tx_pid_seq)
    );

    assign rx_hs = hs_q;

endmodule

// File: rtl/seqtrk_checker.sv
// Property checker for seq_bit_tracker, attached through bind.
module seqtrk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clear_seq,
    input logic       rx_pkt_end,
    input logic [1:0] rx_token,
    input logic       rx_pid_seq,
    input logic       rx_pkt_ok,
    input logic       rx_can_accept,
    input logic       ep_halted,
    input logic       tx_res_valid,
    input logic [1:0] tx_res,
    input logic       rx_accept,
    input logic       rx_discard,
    input logic [1:0] rx_hs,
    input logic       rx_seq,
    input logic       tx_pid_seq
);

    logic good_out;
    logic good_setup;
    assign good_out   = rx_pkt_end && rx_pkt_ok && rx_token == 2'b01;
    assign good_setup = rx_pkt_end && rx_pkt_ok && rx_token == 2'b11;

    a_r2_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear_seq |=> (!rx_seq && !tx_pid_seq));

    a_r3_setup_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (good_setup && !clear_seq) |=> (rx_seq && tx_pid_seq && rx_accept && rx_hs == 2'b01));

    a_r4_take_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (good_out && !ep_halted && rx_can_accept && rx_pid_seq == rx_seq && !clear_seq)
        |=> (rx_accept && rx_hs == 2'b01 && rx_seq != $past(rx_seq)));

    a_r5_repeat_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (good_out && !ep_halted && rx_can_accept && rx_pid_seq != rx_seq && !clear_seq)
        |=> (rx_discard && !rx_accept && rx_hs == 2'b01 && $stable(rx_seq)));

    a_r6_busy_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (good_out && !ep_halted && !rx_can_accept && !clear_seq)
        |=> (rx_hs == 2'b10 && !rx_accept && !rx_discard && $stable(rx_seq)));

    a_r7_halt_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (good_out && ep_halted && !clear_seq)
        |=> (rx_hs == 2'b11 && !rx_accept && !rx_discard && $stable(rx_seq)));

    a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_res_valid && tx_res != 2'b00 && !good_setup && !clear_seq) |=> $stable(tx_pid_seq));

    a_r11_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pkt_end |=> (!rx_accept && !rx_discard && rx_hs == 2'b00));

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_accept && rx_discard));

endmodule

bind seq_bit_tracker seqtrk_checker i_seqtrk_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_seq     (clear_seq),
    .rx_pkt_end    (rx_pkt_end),
    .rx_token      (rx_token),
    .rx_pid_seq    (rx_pid_seq),
    .rx_pkt_ok     (rx_pkt_ok),
    .rx_can_accept (rx_can_accept),
    .ep_halted     (ep_halted),
    .tx_res_valid  (tx_res_valid),
    .tx_res        (tx_res),
    .rx_accept     (rx_accept),
    .rx_discard    (rx_discard),
    .rx_hs         (rx_hs),
    .rx_seq        (rx_seq),
    .tx_pid_seq    (tx_pid_seq)
);

// File: tb/test_seq_bit_tracker.sv
// Exhaustive sweep bench for seq_bit_tracker.
module test_seq_bit_tracker;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_seq = 1'b0;
    logic       rx_pkt_end = 1'b0;
    logic [1:0] rx_token = 2'b00;
    logic       rx_pid_seq = 1'b0;
    logic       rx_pkt_ok = 1'b0;
    logic       rx_can_accept = 1'b0;
    logic       ep_halted = 1'b0;
    logic       tx_res_valid = 1'b0;
    logic [1:0] tx_res = 2'b00;
    logic       rx_accept;
    logic       rx_discard;
    logic [1:0] rx_hs;
    logic       rx_seq;
    logic       tx_pid_seq;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  m_rx = 1'b0;
    bit  m_tx = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seq_bit_tracker i_seq_bit_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear_seq     (clear_seq),
        .rx_pkt_end    (rx_pkt_end),
        .rx_token      (rx_token),
        .rx_pid_seq    (rx_pid_seq),
        .rx_pkt_ok     (rx_pkt_ok),
        .rx_can_accept (rx_can_accept),
        .ep_halted     (ep_halted),
        .tx_res_valid  (tx_res_valid),
        .tx_res        (tx_res),
        .rx_accept     (rx_accept),
        .rx_discard    (rx_discard),
        .rx_hs         (rx_hs),
        .rx_seq        (rx_seq),
        .tx_pid_seq    (tx_pid_seq)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // R2: clear request, both bits to 0.
    task automatic do_clear();
        @(negedge clk);
        clear_seq = 1'b1;
        @(negedge clk);
        clear_seq = 1'b0;
        m_rx = 1'b0;
        m_tx = 1'b0;
        chk("R2 rx bit after clear", rx_seq, 0);
        chk("R2 tx bit after clear", tx_pid_seq, 0);
    endtask

    // R10: one transmit result.
    task automatic do_tx(input logic [1:0] code);
        @(negedge clk);
        tx_res_valid = 1'b1;
        tx_res = code;
        @(negedge clk);
        tx_res_valid = 1'b0;
        if (code == 2'b00) m_tx = ~m_tx;
        chk($sformatf("R10 tx bit after result %0d", code), tx_pid_seq, m_tx);
    endtask

    // One received packet, expected result computed from the requirements.
    task automatic do_pkt(input logic [1:0] tok, input bit pid, input bit ok,
                          input bit can, input bit halt);
        int    e_acc = 0;
        int    e_dis = 0;
        int    e_hs = 0;
        bit    n_rx = m_rx;
        bit    n_tx = m_tx;
        string req = "R9";
        if (tok == 2'b11) begin
            if (ok) begin
                e_acc = 1; e_hs = 1; n_rx = 1'b1; n_tx = 1'b1; req = "R3";
            end else req = "R8";
        end else if (tok == 2'b01) begin
            if (!ok)            req = "R8";
            else if (halt)      begin e_hs = 3; req = "R7"; end
            else if (!can)      begin e_hs = 2; req = "R6"; end
            else if (pid == m_rx) begin e_acc = 1; e_hs = 1; n_rx = ~m_rx; req = "R4"; end
            else                begin e_dis = 1; e_hs = 1; req = "R5"; end
        end
        @(negedge clk);
        rx_pkt_end = 1'b1;
        rx_token = tok;
        rx_pid_seq = pid;
        rx_pkt_ok = ok;
        rx_can_accept = can;
        ep_halted = halt;
        @(negedge clk);
        rx_pkt_end = 1'b0;
        m_rx = n_rx;
        m_tx = n_tx;
        chk({req, " accept strobe"}, rx_accept, e_acc);
        chk({req, " discard strobe"}, rx_discard, e_dis);
        chk({req, " handshake"}, rx_hs, e_hs);
        chk({req, " rx bit"}, rx_seq, m_rx);
        chk({req, " tx bit"}, tx_pid_seq, m_tx);
        @(negedge clk);
        chk("R11 accept drops", rx_accept, 0);
        chk("R11 discard drops", rx_discard, 0);
        chk("R11 handshake drops", rx_hs, 0);
    endtask

    // Reach a chosen pair of starting bits through the normal interface.
    task automatic set_state(input bit r, input bit t);
        do_clear();
        if (r) do_pkt(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        if (m_tx != t) do_tx(2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rx bit at reset", rx_seq, 0);
        chk("R1 tx bit at reset", tx_pid_seq, 0);
        chk("R1 accept at reset", rx_accept, 0);
        chk("R1 discard at reset", rx_discard, 0);
        chk("R1 handshake at reset", rx_hs, 0);

        // Exhaustive receive sweep from every starting bit pair.
        for (int r = 0; r < 2; r++)
            for (int t = 0; t < 2; t++)
                for (int tok = 0; tok < 4; tok++)
                    for (int v = 0; v < 16; v++) begin
                        set_state(r[0], t[0]);
                        do_pkt(tok[1:0], v[0], v[1], v[2], v[3]);
                    end

        // Transmit outcomes from both starting values, plus a retry run.
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 2; s++) begin
                set_state(1'b0, s[0]);
                do_tx(c[1:0]);
                do_tx(c[1:0]);
            end

        // R2: clear in the same cycle as a matching OUT packet.
        set_state(1'b0, 1'b1);
        @(negedge clk);
        clear_seq = 1'b1;
        rx_pkt_end = 1'b1; rx_token = 2'b01; rx_pid_seq = 1'b0;
        rx_pkt_ok = 1'b1; rx_can_accept = 1'b1; ep_halted = 1'b0;
        @(negedge clk);
        clear_seq = 1'b0;
        rx_pkt_end = 1'b0;
        m_rx = 1'b0; m_tx = 1'b0;
        chk("R2 clear beats toggle rx", rx_seq, 0);
        chk("R2 clear beats toggle tx", tx_pid_seq, 0);

        // R3: SETUP together with a transmit ACK leaves tx at 1.
        set_state(1'b0, 1'b1);
        @(negedge clk);
        rx_pkt_end = 1'b1; rx_token = 2'b11; rx_pid_seq = 1'b0; rx_pkt_ok = 1'b1;
        tx_res_valid = 1'b1; tx_res = 2'b00;
        @(negedge clk);
        rx_pkt_end = 1'b0;
        tx_res_valid = 1'b0;
        m_rx = 1'b1; m_tx = 1'b1;
        chk("R3 setup beats tx ack", tx_pid_seq, 1);
        chk("R3 setup rx bit", rx_seq, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule